// File: doc/BRIEF.md
# One-Time-Programmable Fuse Word Programmer

This block is the bus-facing engine that burns a single 32-bit word of a one-time-programmable fuse array. Software selects a word and arms the block with a per-access key through a control register. The write of the data register then starts a programming run. The block reads the target word from the array first, so that fuses already blown are never pulsed again. It then walks the word from bit 0 to bit 31 and fires one program strobe for each bit that still needs blowing. Between steps it waits for a programmable relax gap. After the last step it holds the array quiet for a fixed recovery window before it reports idle.

The register bus is a single-cycle, always-accepting write port with a combinational read port. There is no back-pressure: every write is taken in the cycle it is presented, and an operation that cannot run sets a sticky error flag. The fuse side uses plain strobes. Lock policy for each word arrives on an input vector. A word that is locked produces an error and never touches the array.

Top module: `otp_prog_ctrl`

## Requirements
- R1: After reset the control register (offset 0x00) reads 0, the data register (0x20) reads 0, the timing register (0x10) reads its reset default, and `busy`, `fuse_rd_en` and `fuse_prog_strobe` are low.
- R2: A write to the data register while the key field holds anything other than 0x3E77 stores the value, which reads back, and starts no array activity.
- R3: Programming starts only when all of these hold: the block is idle, the error flag (control bit 9) is clear, the key field (control bits 31:16) holds 0x3E77, the word selected by control bits 6:0 is unlocked, and the data register is written. In that case `busy` and control bit 8 are high from the next cycle and the key field reads 0. The word address is captured, and later writes to the address field do not move `fuse_addr` before `busy` falls.
- R4: Each run begins with exactly read-width+1 cycles of `fuse_rd_en` on the target word, before any strobe. Only bits that are 1 in the written data and 0 in the fuse word are strobed, so the final word is the old word OR the data.
- R5: Each strobe lasts exactly strobe-width+1 cycles. `fuse_bit_sel` stays constant during a strobe, and the bits are visited in ascending order.
- R6: Consecutive strobes within one run are separated by at least relax+1 low cycles.
- R7: During a run the data register shifts right one place per step with zero fill, so it reads 0 after the run. Bus writes to it while `busy` is high are ignored.
- R8: After the last program step, `busy` stays high with the array idle for RECOVERY_CYCLES cycles, and no array strobe occurs while `busy` is low.
- R9: A start attempt on a word whose bit in `lock_vec` is 1 sets the error flag and clears the key field. It never raises `busy` and never drives the array.
- R10: While the error flag is set, neither a program start nor a reload request is taken. Only writing 1 to bit 9 at offset 0x08 clears the flag; writes to 0x00 and 0x04 leave it unchanged.
- R11: A write to offset 0x04 ORs the written bits into the address and key fields, and a write to 0x08 clears the written bits of those fields.
- R12: Writing 1 to control bit 10 at 0x00 or 0x04 while idle and error-free performs one read strobe of read-width+1 cycles at the current address. Bits 10 and 8 read 1 for its duration.
- R13: The timing register holds the strobe width in bits 11:0, the relax time in bits 15:12 and the read width in bits 21:16. Bits 31:22 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and array clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, accepted in the same cycle |
| bus_addr | input | 8 | Byte offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| lock_vec | input | NUM_WORDS | Per-word program lock, 1 = locked |
| busy | output | 1 | Operation or recovery window in progress |
| fuse_addr | output | ADDR_W | Word address presented to the array |
| fuse_rd_en | output | 1 | Array read strobe |
| fuse_rd_data | input | 32 | Current fuse word at `fuse_addr` |
| fuse_prog_strobe | output | 1 | Program pulse for the selected bit |
| fuse_bit_sel | output | 5 | Bit index within the word being programmed |

## Verification
The bench builds the block with NUM_WORDS = 32 and RECOVERY_CYCLES = 12, and it loads short timing values (strobe 3, relax 2, read 4). With these settings a run that blows all 32 bits finishes in a few hundred cycles. A word whose last strobe is bit 31 goes straight into recovery, so the recovery window can be measured against its exact lower bound. The small address space also lets the error, lock and alias paths be covered next to full, partial and zero-pulse runs.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;

  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_SET    = 8'h04;
  localparam logic [7:0] OFS_CLR    = 8'h08;
  localparam logic [7:0] OFS_TIMING = 8'h10;
  localparam logic [7:0] OFS_DATA   = 8'h20;

  localparam int BIT_ERR    = 9;
  localparam int BIT_RELOAD = 10;

  typedef struct packed {
    logic [5:0]  rd_w;
    logic [3:0]  relax;
    logic [11:0] prog_w;
  } timing_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_READ,
    S_STEP,
    S_PULSE,
    S_RELAX,
    S_RECOVER,
    S_RELOAD
  } seq_state_e;

endpackage

// File: rtl/otp_cycle_cnt.sv
module otp_cycle_cnt #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/otp_ctrl_regs.sv
module otp_ctrl_regs
  import otp_prog_pkg::*;
#(
  parameter int          NUM_WORDS  = 128,
  parameter int          ADDR_W     = 7,
  parameter logic [15:0] UNLOCK_KEY = 16'h3E77,
  parameter timing_t     TIM_RST    = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [7:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic                 busy,
  input  logic [NUM_WORDS-1:0] lock_vec,
  output logic [ADDR_W-1:0]    ctrl_addr,
  output logic [15:0]          unlock_val,
  output logic                 err_flag,
  output timing_t              timing,
  output logic                 load_data,
  output logic                 start_prog,
  output logic                 start_reload
);
  logic wr_ctrl, wr_set, wr_clr, wr_tim, wr_data;
  logic can_start, key_ok, word_locked, lock_fault;

  assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_set  = bus_wr && (bus_addr == OFS_SET);
  assign wr_clr  = bus_wr && (bus_addr == OFS_CLR);
  assign wr_tim  = bus_wr && (bus_addr == OFS_TIMING);
  assign wr_data = bus_wr && (bus_addr == OFS_DATA);

  assign can_start    = !busy && !err_flag;
  assign key_ok       = (unlock_val == UNLOCK_KEY);
  assign word_locked  = lock_vec[ctrl_addr];
  assign load_data    = wr_data && can_start;
  assign start_prog   = load_data && key_ok && !word_locked;
  assign lock_fault   = load_data && key_ok && word_locked;
  assign start_reload = (wr_ctrl || wr_set) && bus_wdata[BIT_RELOAD] && can_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_addr  <= '0;
      unlock_val <= '0;
      err_flag   <= 1'b0;
      timing     <= TIM_RST;
    end else begin
      if (wr_ctrl) begin
        ctrl_addr  <= bus_wdata[ADDR_W-1:0];
        unlock_val <= bus_wdata[31:16];
      end else if (wr_set) begin
        ctrl_addr  <= ctrl_addr | bus_wdata[ADDR_W-1:0];
        unlock_val <= unlock_val | bus_wdata[31:16];
      end else if (wr_clr) begin
        ctrl_addr  <= ctrl_addr & ~bus_wdata[ADDR_W-1:0];
        unlock_val <= unlock_val & ~bus_wdata[31:16];
        if (bus_wdata[BIT_ERR]) err_flag <= 1'b0;
      end else if (wr_tim) begin
        timing <= timing_t'(bus_wdata[21:0]);
      end else if (load_data && key_ok) begin
        unlock_val <= '0;
        if (lock_fault) err_flag <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
  import otp_prog_pkg::*;
#(
  parameter int ADDR_W          = 7,
  parameter int DATA_W          = 32,
  parameter int CNT_W           = 12,
  parameter int RECOVERY_CYCLES = 100,
  localparam int BIT_W          = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_prog,
  input  logic              start_reload,
  input  logic              load_data,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  timing_t           timing,
  input  logic [DATA_W-1:0] fuse_rd_data,
  output logic              busy,
  output logic              reloading,
  output logic [DATA_W-1:0] data_q,
  output logic [ADDR_W-1:0] fuse_addr,
  output logic              fuse_rd_en,
  output logic              fuse_prog_strobe,
  output logic [BIT_W-1:0]  fuse_bit_sel
);
  localparam logic [CNT_W-1:0] REC_LOAD = CNT_W'(RECOVERY_CYCLES - 1);

  seq_state_e       st, nxt;
  logic [BIT_W-1:0] bit_idx;
  logic [ADDR_W-1:0] addr_q;
  logic             cnt_load, cnt_zero, shift, mask, step_done, last_bit;
  logic [CNT_W-1:0] cnt_val;

  otp_cycle_cnt #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  assign last_bit = (bit_idx == BIT_W'(DATA_W - 1));

  always_comb begin
    nxt       = st;
    cnt_load  = 1'b0;
    cnt_val   = '0;
    shift     = 1'b0;
    mask      = 1'b0;
    step_done = 1'b0;
    unique case (st)
      S_IDLE: begin
        if (start_prog) begin
          nxt = S_READ;   cnt_load = 1'b1; cnt_val = CNT_W'(timing.rd_w);
        end else if (start_reload) begin
          nxt = S_RELOAD; cnt_load = 1'b1; cnt_val = CNT_W'(timing.rd_w);
        end
      end
      S_READ:    if (cnt_zero) begin mask = 1'b1; nxt = S_STEP; end
      S_STEP: begin
        if (data_q[0]) begin
          nxt = S_PULSE; cnt_load = 1'b1; cnt_val = CNT_W'(timing.prog_w);
        end else begin
          step_done = 1'b1;
        end
      end
      S_PULSE:   if (cnt_zero) step_done = 1'b1;
      S_RELAX:   if (cnt_zero) nxt = S_STEP;
      S_RECOVER: if (cnt_zero) nxt = S_IDLE;
      S_RELOAD:  if (cnt_zero) nxt = S_IDLE;
      default:   nxt = S_IDLE;
    endcase
    if (step_done) begin
      shift    = 1'b1;
      cnt_load = 1'b1;
      if (last_bit) begin
        nxt = S_RECOVER; cnt_val = REC_LOAD;
      end else begin
        nxt = S_RELAX;   cnt_val = CNT_W'(timing.relax);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      bit_idx <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      st <= nxt;
      if (st == S_IDLE) bit_idx <= '0;
      else if (shift)   bit_idx <= bit_idx + 1'b1;
      if (st == S_IDLE && (start_prog || start_reload)) addr_q <= tgt_addr;
      if (st == S_IDLE && load_data) data_q <= wdata;
      else if (mask)                 data_q <= data_q & ~fuse_rd_data;
      else if (shift)                data_q <= data_q >> 1;
    end
  end

  assign busy             = (st != S_IDLE);
  assign reloading        = (st == S_RELOAD);
  assign fuse_addr        = addr_q;
  assign fuse_rd_en       = (st == S_READ) || (st == S_RELOAD);
  assign fuse_prog_strobe = (st == S_PULSE);
  assign fuse_bit_sel     = bit_idx;
endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
  import otp_prog_pkg::*;
#(
  parameter int          NUM_WORDS       = 128,
  parameter int          RECOVERY_CYCLES = 100,
  parameter logic [15:0] UNLOCK_KEY      = 16'h3E77,
  parameter logic [11:0] PROG_W_RST      = 12'd100,
  parameter logic [3:0]  RELAX_RST       = 4'd1,
  parameter logic [5:0]  READ_W_RST      = 6'd8,
  localparam int ADDR_W = $clog2(NUM_WORDS),
  localparam int DATA_W = 32,
  localparam int BIT_W  = $clog2(DATA_W),
  localparam int REC_W  = $clog2(RECOVERY_CYCLES + 1),
  localparam int CNT_W  = (REC_W > 12) ? REC_W : 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [7:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_WORDS-1:0] lock_vec,
  output logic                 busy,
  output logic [ADDR_W-1:0]    fuse_addr,
  output logic                 fuse_rd_en,
  input  logic [31:0]          fuse_rd_data,
  output logic                 fuse_prog_strobe,
  output logic [BIT_W-1:0]     fuse_bit_sel
);
  localparam timing_t TIM_RST = '{rd_w: READ_W_RST, relax: RELAX_RST, prog_w: PROG_W_RST};

  logic [ADDR_W-1:0] ctrl_addr;
  logic [15:0]       unlock_val;
  logic              err_flag, load_data, start_prog, start_reload, reloading;
  timing_t           timing;
  logic [DATA_W-1:0] data_q;
  logic [31:0]       ctrl_word;

  otp_ctrl_regs #(
    .NUM_WORDS (NUM_WORDS), .ADDR_W (ADDR_W),
    .UNLOCK_KEY(UNLOCK_KEY), .TIM_RST (TIM_RST)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .busy        (busy),
    .lock_vec    (lock_vec),
    .ctrl_addr   (ctrl_addr),
    .unlock_val  (unlock_val),
    .err_flag    (err_flag),
    .timing      (timing),
    .load_data   (load_data),
    .start_prog  (start_prog),
    .start_reload(start_reload)
  );

  otp_prog_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .RECOVERY_CYCLES(RECOVERY_CYCLES)
  ) u_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_prog      (start_prog),
    .start_reload    (start_reload),
    .load_data       (load_data),
    .wdata           (bus_wdata),
    .tgt_addr        (ctrl_addr),
    .timing          (timing),
    .fuse_rd_data    (fuse_rd_data),
    .busy            (busy),
    .reloading       (reloading),
    .data_q          (data_q),
    .fuse_addr       (fuse_addr),
    .fuse_rd_en      (fuse_rd_en),
    .fuse_prog_strobe(fuse_prog_strobe),
    .fuse_bit_sel    (fuse_bit_sel)
  );

  assign ctrl_word = {unlock_val, 5'b0, reloading, err_flag, busy,
                      {(8 - ADDR_W){1'b0}}, ctrl_addr};

  always_comb begin
    unique case (bus_addr)
      OFS_CTRL, OFS_SET, OFS_CLR: bus_rdata = ctrl_word;
      OFS_TIMING:                 bus_rdata = {10'b0, timing};
      OFS_DATA:                   bus_rdata = data_q;
      default:                    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/otp_prog_ctrl_chk.sv
module otp_prog_ctrl_chk
  import otp_prog_pkg::*;
#(
  parameter int          NUM_WORDS       = 128,
  parameter int          RECOVERY_CYCLES = 100,
  parameter logic [15:0] UNLOCK_KEY      = 16'h3E77,
  localparam int ADDR_W = $clog2(NUM_WORDS),
  localparam int Q_W    = $clog2(RECOVERY_CYCLES + 1) + 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_wr,
  input logic [7:0]           bus_addr,
  input logic [31:0]          bus_wdata,
  input logic [NUM_WORDS-1:0] lock_vec,
  input logic                 busy,
  input logic                 err_flag,
  input logic [ADDR_W-1:0]    ctrl_addr,
  input logic [15:0]          unlock_val,
  input logic [ADDR_W-1:0]    fuse_addr,
  input logic                 fuse_rd_en,
  input logic                 fuse_prog_strobe,
  input logic [4:0]           fuse_bit_sel
);
  logic           try_start, err_clear;
  logic [Q_W-1:0] quiet;
  logic           unused_wdata;

  assign try_start = bus_wr && (bus_addr == OFS_DATA) && !busy && !err_flag &&
                     (unlock_val == UNLOCK_KEY);
  assign err_clear = bus_wr && (bus_addr == OFS_CLR) && bus_wdata[BIT_ERR];
  assign unused_wdata = ^{bus_wdata[31:10], bus_wdata[8:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 quiet <= Q_W'(RECOVERY_CYCLES);
    else if (fuse_prog_strobe)                  quiet <= '0;
    else if (quiet < Q_W'(RECOVERY_CYCLES))     quiet <= quiet + 1'b1;
  end

  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    try_start && !lock_vec[ctrl_addr] |=> busy && (unlock_val == 16'h0));

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(fuse_addr));

  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(fuse_rd_en && fuse_prog_strobe));

  p_strobe_in_op_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_prog_strobe |-> busy);

  p_sel_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_prog_strobe && $past(fuse_prog_strobe) |-> $stable(fuse_bit_sel));

  p_recovery_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> quiet >= Q_W'(RECOVERY_CYCLES));

  p_lock_error_r9: assert property (@(posedge clk) disable iff (!rst_n)
    try_start && lock_vec[ctrl_addr] |=> !busy && err_flag);

  p_err_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !busy |=> !busy);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !err_clear |=> err_flag);
endmodule

bind otp_prog_ctrl otp_prog_ctrl_chk #(
  .NUM_WORDS(NUM_WORDS), .RECOVERY_CYCLES(RECOVERY_CYCLES), .UNLOCK_KEY(UNLOCK_KEY)
) u_chk (.*);

// File: tb/otp_prog_ctrl_tb.sv
module otp_prog_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 32;
  localparam int REC = 12;
  localparam int T_PROG = 3, T_RELAX = 2, T_READ = 4;
  localparam logic [31:0] TIM_DEF = 32'h0008_1064;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NW-1:0] lock_vec = '0;
  logic        busy, fuse_rd_en, fuse_prog_strobe;
  logic [4:0]  fuse_addr, fuse_bit_sel;
  logic [31:0] fuse_rd_data;

  logic [31:0] fmem [NW];
  logic        pre_en = 1'b0;
  int          pre_addr = 0;
  logic [31:0] pre_val = '0;

  int n_vec = 0, n_bad = 0, cyc = 0, tot_rd = 0;
  bit run_done = 1'b0;

  typedef struct { bit is_reload; int addr; logic [31:0] word; int pulses; } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  otp_prog_ctrl #(
    .NUM_WORDS(NW), .RECOVERY_CYCLES(REC), .UNLOCK_KEY(16'h3E77),
    .PROG_W_RST(12'd100), .RELAX_RST(4'd1), .READ_W_RST(6'd8)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lock_vec(lock_vec),
    .busy(busy), .fuse_addr(fuse_addr), .fuse_rd_en(fuse_rd_en),
    .fuse_rd_data(fuse_rd_data), .fuse_prog_strobe(fuse_prog_strobe),
    .fuse_bit_sel(fuse_bit_sel)
  );

  assign fuse_rd_data = fmem[fuse_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) fmem[i] <= '0;
    end else if (pre_en) begin
      fmem[pre_addr] <= pre_val;
    end else if (fuse_prog_strobe) begin
      fmem[fuse_addr][fuse_bit_sel] <= 1'b1;
    end
  end

  task automatic finish_run();
    if (!run_done) begin
      run_done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic preload(input int a, input logic [31:0] v);
    @(negedge clk);
    pre_en = 1'b1; pre_addr = a; pre_val = v;
    @(negedge clk);
    pre_en = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic program_word(input int a, input logic [31:0] old_w, input logic [31:0] d);
    exp_t e;
    logic [31:0] m;
    int np;
    m = d & ~old_w;
    np = $countones(m);
    e.is_reload = 1'b0; e.addr = a; e.word = old_w | d; e.pulses = np;
    preload(a, old_w);
    sb_q.push_back(e);
    bus_write(8'h00, {16'h3E77, 11'b0, 5'(a)});
    bus_write(8'h20, d);
  endtask

  // Monitor / scoreboard
  bit busy_prev = 1'b0, stb_prev = 1'b0;
  int pulses = 0, rd_cyc = 0, rd_addr = -1, pw = 0, gap = 0, quiet = 0, last_sel = -1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (fuse_rd_en) tot_rd++;
      if (!busy && (fuse_rd_en || fuse_prog_strobe))
        chk(1'b0, "R8 array active while idle", 32'(fuse_prog_strobe), 32'h0);
      if (busy) begin
        if (fuse_rd_en) begin
          rd_cyc++;
          rd_addr = int'(fuse_addr);
          if (pulses > 0) chk(1'b0, "R4 read after strobe", 32'(pulses), 32'h0);
        end
        if (fuse_prog_strobe) begin
          if (!stb_prev) begin
            if (pulses > 0) begin
              chk(gap >= T_RELAX + 1, "R6 relax gap", 32'(gap), 32'(T_RELAX + 1));
              chk(int'(fuse_bit_sel) > last_sel, "R5 ascending bit order", 32'(fuse_bit_sel), 32'(last_sel));
            end
            chk(fmem[fuse_addr][fuse_bit_sel] == 1'b0, "R4 strobe on blown bit", 32'(fuse_bit_sel), 32'h0);
            chk(int'(fuse_addr) == rd_addr, "R3 strobe address", 32'(fuse_addr), 32'(rd_addr));
            pulses++;
            last_sel = int'(fuse_bit_sel);
            gap = 0;
          end
          pw++;
          quiet = 0;
        end else begin
          if (stb_prev) begin
            chk_eq("R5 strobe width", 32'(pw), 32'(T_PROG + 1));
            pw = 0;
          end
          gap++;
          quiet++;
        end
      end
      if (busy_prev && !busy) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R3 unexpected operation", 32'h1, 32'h0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk_eq(e.is_reload ? "R12 reload read width" : "R4 pre-read width", 32'(rd_cyc), 32'(T_READ + 1));
          if (e.is_reload) begin
            chk_eq("R12 reload makes no strobe", 32'(pulses), 32'h0);
          end else begin
            chk_eq("R4 strobe count", 32'(pulses), 32'(e.pulses));
            chk_eq("R4 final fuse word", fmem[e.addr], e.word);
            chk_eq("R3 latched address", 32'(rd_addr), 32'(e.addr));
            if (pulses > 0) chk(quiet >= REC, "R8 recovery window", 32'(quiet), 32'(REC));
          end
        end
        pulses = 0; rd_cyc = 0; pw = 0; gap = 0; quiet = 0; last_sel = -1;
      end
      busy_prev = busy;
      stb_prev = fuse_prog_strobe;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog expired", 32'(cyc), 32'h0);
      finish_run();
    end
  end

  initial begin
    logic [31:0] rd;
    int snap;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(8'h00, rd); chk_eq("R1 ctrl reset", rd, 32'h0);
    bus_read(8'h10, rd); chk_eq("R1 timing reset", rd, TIM_DEF);
    bus_read(8'h20, rd); chk_eq("R1 data reset", rd, 32'h0);
    chk_eq("R1 idle outputs", {busy, fuse_rd_en, fuse_prog_strobe}, 3'b000);

    // R13 timing layout
    bus_write(8'h10, 32'hFFC0_0000 | (T_READ << 16) | (T_RELAX << 12) | T_PROG);
    bus_read(8'h10, rd); chk_eq("R13 timing readback", rd, 32'h0004_2003);

    // R2 data write without key
    snap = tot_rd;
    bus_write(8'h20, 32'h0000_A5A5);
    bus_read(8'h20, rd); chk_eq("R2 data stored", rd, 32'h0000_A5A5);
    repeat (30) @(negedge clk);
    chk_eq("R2 no start", {31'b0, busy}, 32'h0);
    chk_eq("R2 no array read", 32'(tot_rd), 32'(snap));

    // R3/R4/R7 partial word with pre-blown bits, address moved mid-run
    program_word(3, 32'h0000_0030, 32'h0000_00F0);
    chk_eq("R3 busy after start", {31'b0, busy}, 32'h1);
    bus_read(8'h00, rd); chk_eq("R3 key cleared, busy bit", rd, 32'h0000_0103);
    bus_write(8'h00, 32'h0000_0005);
    bus_write(8'h20, 32'hFFFF_FFFF);
    wait_idle();
    bus_read(8'h20, rd); chk_eq("R7 data shifted out", rd, 32'h0);
    chk_eq("R3 moved address untouched", fmem[5], 32'h0);

    // R5/R8 full word, last strobe on bit 31
    program_word(10, 32'h0, 32'hFFFF_FFFF);
    wait_idle();
    // single bit 0 with bit 31 already blown
    program_word(0, 32'h8000_0000, 32'h8000_0001);
    wait_idle();
    // R4 nothing new to blow
    program_word(12, 32'hFFFF_0000, 32'h00FF_0000);
    wait_idle();

    // R9 locked word
    lock_vec[7] = 1'b1;
    snap = tot_rd;
    bus_write(8'h00, 32'h3E77_0007);
    bus_write(8'h20, 32'h0000_0001);
    chk_eq("R9 no busy", {31'b0, busy}, 32'h0);
    bus_read(8'h00, rd); chk_eq("R9 error set, key cleared", rd, 32'h0000_0207);
    repeat (10) @(negedge clk);
    chk_eq("R9 no array access", 32'(tot_rd), 32'(snap));

    // R10 error blocks starts and reloads
    bus_write(8'h00, 32'h3E77_0004);
    bus_write(8'h20, 32'h0000_0001);
    chk_eq("R10 start refused", {31'b0, busy}, 32'h0);
    bus_write(8'h04, 32'h0000_0400);
    chk_eq("R10 reload refused", {31'b0, busy}, 32'h0);
    repeat (10) @(negedge clk);
    chk_eq("R10 word untouched", fmem[4], 32'h0);
    chk_eq("R10 no array read", 32'(tot_rd), 32'(snap));
    bus_write(8'h00, 32'h3E77_0004);
    bus_read(8'h00, rd); chk_eq("R10 plain write keeps error", rd, 32'h3E77_0204);
    bus_write(8'h08, 32'h0000_0200);
    bus_read(8'h00, rd); chk_eq("R10 clear alias drops error", rd, 32'h3E77_0004);

    // R11 set / clear aliases
    bus_write(8'h00, 32'h0000_0005);
    bus_write(8'h04, 32'h3E77_0002);
    bus_read(8'h00, rd); chk_eq("R11 set alias", rd, 32'h3E77_0007);
    bus_write(8'h08, 32'h3E77_0001);
    bus_read(8'h00, rd); chk_eq("R11 clear alias", rd, 32'h0000_0006);

    // R12 reload
    begin
      exp_t e;
      e.is_reload = 1'b1; e.addr = 6; e.word = '0; e.pulses = 0;
      sb_q.push_back(e);
    end
    bus_write(8'h00, 32'h0000_0406);
    bus_read(8'h00, rd); chk_eq("R12 reload in progress", rd, 32'h0000_0506);
    wait_idle();
    bus_read(8'h00, rd); chk_eq("R12 reload done", rd, 32'h0000_0006);

    // Program after error recovery, key armed through set alias
    preload(4, 32'h0);
    begin
      exp_t e;
      e.is_reload = 1'b0; e.addr = 4; e.word = 32'h0000_0F0F; e.pulses = 8;
      sb_q.push_back(e);
    end
    bus_write(8'h00, 32'h0000_0004);
    bus_write(8'h04, 32'h3E77_0000);
    bus_write(8'h20, 32'h0000_0F0F);
    chk_eq("R3 start via set alias", {31'b0, busy}, 32'h1);
    wait_idle();

    chk_eq("R3 all operations observed", 32'(sb_q.size()), 32'h0);
    finish_run();
  end
endmodule